// File: doc/BRIEF.md
# Power-Up Sleep and Reset Sequencer

This block orders the release of a platform's active-low sleep-state, suspend-status and PCI reset outputs during power-up. It runs once the supply-good conditions are reported. Most of the ordering runs in a slow real-time-clock domain of about 32 kHz. The outputs leave their asserted (low) levels one after another, each a fixed number of slow cycles after the step before it.

The processor frequency straps are handled in a second, fast clock domain of about 66 MHz. The strap latch stays engaged while suspend status is asserted. It is freed a fixed number of fast cycles after the processor reports that its reset has completed.

If the power or voltage indication drops, or a system reset is requested, suspend status and the PCI reset go back to their asserted levels at once and the straps are held again. If the resume-well reset is asserted, every output returns to its power-on state.

Top module: `pwr_wake_seq`

## Requirements
- R1: During and directly after the synchronous resets, all five active-low outputs (`slp_s5_n`, `slp_s4_n`, `slp_s3_n`, `sus_stat_n`, `pci_rst_n`) read 0, `susclk_en` reads 0 and `strap_hold` reads 1.
- R2: While `rsm_rst_n` is low, the five active-low outputs and `susclk_en` are 0. A low `rsm_rst_n` sampled on any slow edge forces them all to 0 after that edge.
- R3: On the first slow edge that samples `rsm_rst_n` high, `slp_s5_n` goes to 1 and `susclk_en` goes to 1.
- R4: `slp_s4_n` goes to 1 exactly `S4_DLY` (default 2) slow edges after `slp_s5_n` rose.
- R5: `slp_s3_n` goes to 1 exactly `S3_DLY` (default 2) slow edges after `slp_s4_n` rose.
- R6: `sus_stat_n` stays 0 until a slow edge samples `pwr_ok`, `vgate_ok` and `sys_rst_n` all high. It then goes to 1 exactly `SUS_DLY` (default 35) slow edges after that edge, provided the three inputs stay high throughout.
- R7: `pci_rst_n` goes to 1 exactly `PCI_DLY` (default 2) slow edges after `sus_stat_n` rose.
- R8: A slow edge that samples `pwr_ok` low, `vgate_ok` low or `sys_rst_n` low drives `sus_stat_n` and `pci_rst_n` to 0 after that edge. `slp_s5_n`, `slp_s4_n` and `slp_s3_n` are left at 1. Within 3 fast edges after that slow edge, `strap_hold` returns to 1.
- R9: `strap_hold` stays 1 while `sus_stat_n` is 0. A `cpu_rst_done` pulse that arrives in that period has no effect.
- R10: `cpu_rst_done` is a one-slow-cycle high pulse, taken on a slow edge while `sus_stat_n` is 1. After it is taken, `strap_hold` falls on the fast edge that comes `3 + STRAP_DLY` (default 11) fast edges after that slow edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slow_clk | input | 1 | Slow real-time clock, about 32 kHz |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| fast_clk | input | 1 | Fast clock, about 66 MHz |
| fast_rst | input | 1 | Synchronous active-high reset, fast domain |
| rsm_rst_n | input | 1 | Resume-well reset, low = asserted |
| pwr_ok | input | 1 | Main power good |
| vgate_ok | input | 1 | Core voltage good |
| sys_rst_n | input | 1 | System reset request, low = requested |
| cpu_rst_done | input | 1 | Processor reset complete, one slow-cycle pulse |
| slp_s5_n | output | 1 | Soft-off sleep control, low = asserted |
| slp_s4_n | output | 1 | Suspend-to-disk sleep control, low = asserted |
| slp_s3_n | output | 1 | Suspend-to-RAM sleep control, low = asserted |
| sus_stat_n | output | 1 | Suspend status, low = asserted |
| pci_rst_n | output | 1 | PCI reset, low = asserted |
| susclk_en | output | 1 | Suspend clock enable |
| strap_hold | output | 1 | 1 = frequency straps latched to strap values |

## Verification
Every slow-domain output is registered. A change shows up right after the slow edge that takes the input, or after the edge that ends a count. The bench drives inputs and samples outputs 5 ns after slow rising edges and counts edges one by one, checking each result on its exact edge and also one edge earlier.

The strap release lands 3 fast edges of synchronizer latency plus `STRAP_DLY` fast edges after the slow edge that takes `cpu_rst_done`. The two clocks are chosen so their edges never coincide, and the bench samples `strap_hold` 1 ns on either side of the expected fast edge. Strap re-hold after an abort is checked once the 3 fast edges of latency have passed.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

    typedef enum logic [2:0] {
        ST_RSM_HOLD,
        ST_S5_UP,
        ST_S4_UP,
        ST_PWR_WAIT,
        ST_SUS_CNT,
        ST_SUS_UP,
        ST_RUN
    } seq_state_e;

    typedef enum logic [1:0] {
        SR_HOLD,
        SR_COUNT,
        SR_FREE
    } strap_state_e;

    typedef struct packed {
        logic slp_s5_n;
        logic slp_s4_n;
        logic slp_s3_n;
        logic sus_stat_n;
        logic pci_rst_n;
        logic susclk_en;
    } seq_out_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic seq_out_t decode_outputs(input seq_state_e s);
        seq_out_t o;
        o = '0;
        unique case (s)
            ST_RSM_HOLD: o = '0;
            ST_S5_UP: begin
                o.slp_s5_n  = 1'b1;
                o.susclk_en = 1'b1;
            end
            ST_S4_UP: begin
                o.slp_s5_n  = 1'b1;
                o.slp_s4_n  = 1'b1;
                o.susclk_en = 1'b1;
            end
            ST_PWR_WAIT, ST_SUS_CNT: begin
                o.slp_s5_n  = 1'b1;
                o.slp_s4_n  = 1'b1;
                o.slp_s3_n  = 1'b1;
                o.susclk_en = 1'b1;
            end
            ST_SUS_UP: begin
                o.slp_s5_n   = 1'b1;
                o.slp_s4_n   = 1'b1;
                o.slp_s3_n   = 1'b1;
                o.sus_stat_n = 1'b1;
                o.susclk_en  = 1'b1;
            end
            ST_RUN: begin
                o.slp_s5_n   = 1'b1;
                o.slp_s4_n   = 1'b1;
                o.slp_s3_n   = 1'b1;
                o.sus_stat_n = 1'b1;
                o.pci_rst_n  = 1'b1;
                o.susclk_en  = 1'b1;
            end
            default: o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/pwr_wake_pulse_xfer.sv
module pwr_wake_pulse_xfer #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_pulse
);
    logic src_tgl;
    logic dst_tgl;
    logic dst_tgl_d;

    always_ff @(posedge src_clk) begin
        if (src_rst)        src_tgl <= 1'b0;
        else if (src_pulse) src_tgl <= ~src_tgl;
    end

    pwr_wake_sync #(.STAGES(STAGES)) u_tgl_sync (
        .clk (dst_clk),
        .rst (dst_rst),
        .d   (src_tgl),
        .q   (dst_tgl)
    );

    always_ff @(posedge dst_clk) begin
        if (dst_rst) dst_tgl_d <= 1'b0;
        else         dst_tgl_d <= dst_tgl;
    end

    assign dst_pulse = dst_tgl ^ dst_tgl_d;
endmodule

// File: rtl/pwr_wake_slow_fsm.sv
module pwr_wake_slow_fsm
    import pwr_wake_pkg::*;
#(
    parameter int S4_DLY  = 2,
    parameter int S3_DLY  = 2,
    parameter int SUS_DLY = 35,
    parameter int PCI_DLY = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rsm_rst_n,
    input  logic     pwr_ok,
    input  logic     vgate_ok,
    input  logic     sys_rst_n,
    output seq_out_t outs
);
    localparam int MAX_A = (S4_DLY > S3_DLY) ? S4_DLY : S3_DLY;
    localparam int MAX_B = (SUS_DLY > PCI_DLY) ? SUS_DLY : PCI_DLY;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = cnt_width(MAX_D);
    localparam logic [CW-1:0] L_S4  = CW'(S4_DLY - 1);
    localparam logic [CW-1:0] L_S3  = CW'(S3_DLY - 1);
    localparam logic [CW-1:0] L_SUS = CW'(SUS_DLY - 1);
    localparam logic [CW-1:0] L_PCI = CW'(PCI_DLY - 1);

    seq_state_e    st, nxt;
    logic [CW-1:0] cnt;
    logic          counting;
    logic          good;

    assign good = pwr_ok & vgate_ok & sys_rst_n;

    always_comb begin
        nxt      = st;
        counting = 1'b0;
        unique case (st)
            ST_RSM_HOLD: nxt = ST_S5_UP;
            ST_S5_UP: begin
                counting = 1'b1;
                if (cnt == L_S4) nxt = ST_S4_UP;
            end
            ST_S4_UP: begin
                counting = 1'b1;
                if (cnt == L_S3) nxt = ST_PWR_WAIT;
            end
            ST_PWR_WAIT: if (good) nxt = ST_SUS_CNT;
            ST_SUS_CNT: begin
                counting = 1'b1;
                if (!good)              nxt = ST_PWR_WAIT;
                else if (cnt == L_SUS)  nxt = ST_SUS_UP;
            end
            ST_SUS_UP: begin
                counting = 1'b1;
                if (!good)              nxt = ST_PWR_WAIT;
                else if (cnt == L_PCI)  nxt = ST_RUN;
            end
            ST_RUN: if (!good) nxt = ST_PWR_WAIT;
            default: nxt = ST_RSM_HOLD;
        endcase
        if (!rsm_rst_n) nxt = ST_RSM_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_RSM_HOLD;
            cnt  <= '0;
            outs <= '0;
        end else begin
            st   <= nxt;
            outs <= decode_outputs(nxt);
            if (nxt != st || !counting) cnt <= '0;
            else                        cnt <= cnt + 1'b1;
        end
    end

    // R2
    rsm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rsm_rst_n |=> (outs == '0));

    // R4
    s4_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.slp_s4_n) |-> $past(outs.slp_s5_n));

    // R6
    sus_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.sus_stat_n) |-> $past(good));

    // R7
    pci_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.pci_rst_n) |-> $past(outs.sus_stat_n));

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        !good |=> (!outs.sus_stat_n && !outs.pci_rst_n));
endmodule

// File: rtl/pwr_wake_strap.sv
module pwr_wake_strap
    import pwr_wake_pkg::*;
#(
    parameter int STRAP_DLY = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sus_ok,
    input  logic done_pulse,
    output logic strap_hold
);
    localparam int CW = cnt_width(STRAP_DLY);
    localparam logic [CW-1:0] L_STRAP = CW'(STRAP_DLY - 1);

    strap_state_e  st, nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = st;
        unique case (st)
            SR_HOLD:  if (sus_ok && done_pulse) nxt = SR_COUNT;
            SR_COUNT: begin
                if (!sus_ok)             nxt = SR_HOLD;
                else if (cnt == L_STRAP) nxt = SR_FREE;
            end
            SR_FREE:  if (!sus_ok) nxt = SR_HOLD;
            default:  nxt = SR_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SR_HOLD;
            cnt <= '0;
        end else begin
            st <= nxt;
            if (nxt != st || st != SR_COUNT) cnt <= '0;
            else                             cnt <= cnt + 1'b1;
        end
    end

    assign strap_hold = (st != SR_FREE);

    // R9
    strap_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !strap_hold |-> $past(sus_ok));

    // R9
    strap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && !sus_ok) |=> strap_hold);
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
    import pwr_wake_pkg::*;
#(
    parameter int S4_DLY    = 2,
    parameter int S3_DLY    = 2,
    parameter int SUS_DLY   = 35,
    parameter int PCI_DLY   = 2,
    parameter int STRAP_DLY = 8,
    parameter int SYNC_STG  = 2
) (
    input  logic slow_clk,
    input  logic slow_rst,
    input  logic fast_clk,
    input  logic fast_rst,
    input  logic rsm_rst_n,
    input  logic pwr_ok,
    input  logic vgate_ok,
    input  logic sys_rst_n,
    input  logic cpu_rst_done,
    output logic slp_s5_n,
    output logic slp_s4_n,
    output logic slp_s3_n,
    output logic sus_stat_n,
    output logic pci_rst_n,
    output logic susclk_en,
    output logic strap_hold
);
    seq_out_t outs;
    logic     sus_ok_f;
    logic     done_f;

    pwr_wake_slow_fsm #(
        .S4_DLY  (S4_DLY),
        .S3_DLY  (S3_DLY),
        .SUS_DLY (SUS_DLY),
        .PCI_DLY (PCI_DLY)
    ) u_fsm (
        .clk       (slow_clk),
        .rst       (slow_rst),
        .rsm_rst_n (rsm_rst_n),
        .pwr_ok    (pwr_ok),
        .vgate_ok  (vgate_ok),
        .sys_rst_n (sys_rst_n),
        .outs      (outs)
    );

    pwr_wake_sync #(.STAGES(SYNC_STG)) u_sus_sync (
        .clk (fast_clk),
        .rst (fast_rst),
        .d   (outs.sus_stat_n),
        .q   (sus_ok_f)
    );

    pwr_wake_pulse_xfer #(.STAGES(SYNC_STG)) u_done_xfer (
        .src_clk   (slow_clk),
        .src_rst   (slow_rst),
        .src_pulse (cpu_rst_done),
        .dst_clk   (fast_clk),
        .dst_rst   (fast_rst),
        .dst_pulse (done_f)
    );

    pwr_wake_strap #(.STRAP_DLY(STRAP_DLY)) u_strap (
        .clk        (fast_clk),
        .rst        (fast_rst),
        .sus_ok     (sus_ok_f),
        .done_pulse (done_f),
        .strap_hold (strap_hold)
    );

    assign slp_s5_n   = outs.slp_s5_n;
    assign slp_s4_n   = outs.slp_s4_n;
    assign slp_s3_n   = outs.slp_s3_n;
    assign sus_stat_n = outs.sus_stat_n;
    assign pci_rst_n  = outs.pci_rst_n;
    assign susclk_en  = outs.susclk_en;
endmodule

// File: tb/pwr_wake_seq_test.sv
module pwr_wake_seq_test;
    logic slow_clk = 1'b0;
    logic fast_clk = 1'b0;
    logic slow_rst = 1'b1;
    logic fast_rst = 1'b1;
    logic rsm_rst_n = 1'b0;
    logic pwr_ok = 1'b0;
    logic vgate_ok = 1'b0;
    logic sys_rst_n = 1'b0;
    logic cpu_rst_done = 1'b0;
    logic slp_s5_n, slp_s4_n, slp_s3_n, sus_stat_n, pci_rst_n, susclk_en, strap_hold;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2  fast_clk = ~fast_clk;
    always #20 slow_clk = ~slow_clk;

    pwr_wake_seq uut (
        .slow_clk     (slow_clk),
        .slow_rst     (slow_rst),
        .fast_clk     (fast_clk),
        .fast_rst     (fast_rst),
        .rsm_rst_n    (rsm_rst_n),
        .pwr_ok       (pwr_ok),
        .vgate_ok     (vgate_ok),
        .sys_rst_n    (sys_rst_n),
        .cpu_rst_done (cpu_rst_done),
        .slp_s5_n     (slp_s5_n),
        .slp_s4_n     (slp_s4_n),
        .slp_s3_n     (slp_s3_n),
        .sus_stat_n   (sus_stat_n),
        .pci_rst_n    (pci_rst_n),
        .susclk_en    (susclk_en),
        .strap_hold   (strap_hold)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic slow_step(input int n);
        repeat (n) @(posedge slow_clk);
        #5;
    endtask

    task automatic test_reset;
        repeat (3) @(posedge slow_clk);
        #5;
        slow_rst = 1'b0;
        fast_rst = 1'b0;
        check("R1 sleep outputs", {29'd0, slp_s5_n, slp_s4_n, slp_s3_n}, 32'd0);
        check("R1 sus/pci/clk", {29'd0, sus_stat_n, pci_rst_n, susclk_en}, 32'd0);
        check("R1 strap_hold", {31'd0, strap_hold}, 32'd1);
        slow_step(3);
        check("R2 held under rsm", {26'd0, slp_s5_n, slp_s4_n, slp_s3_n,
              sus_stat_n, pci_rst_n, susclk_en}, 32'd0);
    endtask

    task automatic test_wake;
        rsm_rst_n = 1'b1;
        slow_step(1);
        check("R3 slp_s5_n up", {31'd0, slp_s5_n}, 32'd1);
        check("R3 susclk_en up", {31'd0, susclk_en}, 32'd1);
        check("R4 slp_s4_n early", {31'd0, slp_s4_n}, 32'd0);
        slow_step(1);
        check("R4 slp_s4_n one short", {31'd0, slp_s4_n}, 32'd0);
        slow_step(1);
        check("R4 slp_s4_n due", {31'd0, slp_s4_n}, 32'd1);
        slow_step(1);
        check("R5 slp_s3_n one short", {31'd0, slp_s3_n}, 32'd0);
        slow_step(1);
        check("R5 slp_s3_n due", {31'd0, slp_s3_n}, 32'd1);
        slow_step(6);
        check("R6 sus waits for good", {31'd0, sus_stat_n}, 32'd0);
    endtask

    task automatic test_ignore_done;
        cpu_rst_done = 1'b1;
        slow_step(1);
        cpu_rst_done = 1'b0;
        slow_step(2);
        check("R9 pulse ignored while sus low", {31'd0, strap_hold}, 32'd1);
    endtask

    task automatic test_sus_release;
        pwr_ok = 1'b1;
        vgate_ok = 1'b1;
        sys_rst_n = 1'b1;
        slow_step(1);
        slow_step(34);
        check("R6 sus one short", {31'd0, sus_stat_n}, 32'd0);
        slow_step(1);
        check("R6 sus due", {31'd0, sus_stat_n}, 32'd1);
        check("R7 pci still low", {31'd0, pci_rst_n}, 32'd0);
        slow_step(1);
        check("R7 pci one short", {31'd0, pci_rst_n}, 32'd0);
        slow_step(1);
        check("R7 pci due", {31'd0, pci_rst_n}, 32'd1);
        check("R9 strap held before pulse", {31'd0, strap_hold}, 32'd1);
    endtask

    task automatic test_strap_release;
        cpu_rst_done = 1'b1;
        @(posedge slow_clk);
        #1 cpu_rst_done = 1'b0;
        #40;
        check("R10 strap held one short", {31'd0, strap_hold}, 32'd1);
        #2;
        check("R10 strap freed", {31'd0, strap_hold}, 32'd0);
        slow_step(1);
    endtask

    task automatic test_pwr_abort;
        pwr_ok = 1'b0;
        @(posedge slow_clk);
        #5;
        check("R8 sus back low", {31'd0, sus_stat_n}, 32'd0);
        check("R8 pci back low", {31'd0, pci_rst_n}, 32'd0);
        check("R8 sleep stay high", {29'd0, slp_s5_n, slp_s4_n, slp_s3_n}, 32'd7);
        #8;
        check("R8 strap re-held", {31'd0, strap_hold}, 32'd1);
    endtask

    task automatic test_vgate_only;
        pwr_ok = 1'b1;
        vgate_ok = 1'b0;
        slow_step(40);
        check("R6 vgate low blocks sus", {31'd0, sus_stat_n}, 32'd0);
    endtask

    task automatic test_sysrst_abort;
        vgate_ok = 1'b1;
        slow_step(36);
        check("R6 sus after recovery", {31'd0, sus_stat_n}, 32'd1);
        sys_rst_n = 1'b0;
        slow_step(1);
        check("R8 sysrst drops sus", {31'd0, sus_stat_n}, 32'd0);
        check("R8 sysrst drops pci", {31'd0, pci_rst_n}, 32'd0);
    endtask

    task automatic test_rsm_again;
        sys_rst_n = 1'b1;
        slow_step(40);
        check("R7 pci after recovery", {31'd0, pci_rst_n}, 32'd1);
        rsm_rst_n = 1'b0;
        slow_step(1);
        check("R2 rsm forces all low", {26'd0, slp_s5_n, slp_s4_n, slp_s3_n,
              sus_stat_n, pci_rst_n, susclk_en}, 32'd0);
    endtask

    initial begin
        test_reset();
        test_wake();
        test_ignore_done();
        test_sus_release();
        test_strap_release();
        test_pwr_abort();
        test_vgate_only();
        test_sysrst_abort();
        test_rsm_again();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule